// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This block is the control core of a single-item vending machine with a fixed price of one dollar. Three single-cycle coin strobes report a 25-cent coin, a one-dollar coin and a two-dollar coin. The controller keeps a running credit in quarter units, from zero to 75 cents. When a coin brings the credit up to the price or beyond, it releases one item. In the same cycle it reports the surplus as a binary count of quarters to pay back.

The release and change outputs are combinational from the held credit and the coin strobe present in the current cycle. They are therefore valid within the cycle that meets the price, and the credit update takes effect at the following rising edge. The coin strobes are plain control pins with no back-pressure. Surrounding logic presents at most one coin per cycle. If several strobes arrive together, the largest coin wins and the others are dropped.

Top module: `vend_ctrl`

## Requirements
- R1: While `rst` is high, `dispense` is 0 and `change` is 0 whatever the coin strobes show. The rising edge with `rst` high leaves the credit at zero, so a one-dollar coin in the first cycle after reset returns change 0.
- R2: A quarter (value 1 unit of 25 cents) adds one unit to the credit. On credit 0, 1 or 2 it gives `dispense` 0. On credit 3 (75 cents) it gives `dispense` 1 with `change` 0.
- R3: A one-dollar coin (value 4 units) always gives `dispense` 1, and `change` equals the credit in quarters (0 to 3).
- R4: A two-dollar coin (value 8 units) always gives `dispense` 1, and `change` equals the credit plus 4 (4 to 7). Credit 3 gives 7, the largest 3-bit value.
- R5: After a cycle with `dispense` 1, the credit is zero. Four more quarters are needed for the next release.
- R6: A cycle with no coin strobe leaves the credit unchanged, however many such cycles pass.
- R7: Coin priority is two-dollar over one-dollar over quarter. Lower-valued strobes asserted together with a higher one have no effect on outputs or credit.
- R8: `change` is 0 in every cycle where `dispense` is 0. `dispense` is high only in cycles that carry a coin strobe.
- R9: `dispense` and `change` respond in the same cycle as the coin strobe that meets the price, before the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| coin_qtr | input | 1 | A 25-cent coin was inserted this cycle |
| coin_one | input | 1 | A one-dollar coin was inserted this cycle |
| coin_two | input | 1 | A two-dollar coin was inserted this cycle |
| dispense | output | 1 | Release one item (one-cycle pulse) |
| change | output | 3 | Quarters to return, binary, valid with dispense |

## Verification
The bench targets three things: the two-dollar coin on 75 cents, which must produce 7 with no wrap; the fourth quarter, which must release with zero change; and combined strobes, where a design that summed coins or took the wrong priority would report extra change or keep leftover credit. It also checks that credit survives long idle gaps and that it is cleared both by reset and by a release. A design that kept leftover credit after a release would then dispense too early on the following quarters.

// File: rtl/vend_pkg.sv
package vend_pkg;

  // Coin selected for the current cycle after priority resolution.
  typedef enum logic [1:0] {
    COIN_NONE = 2'd0,
    COIN_QTR  = 2'd1,
    COIN_ONE  = 2'd2,
    COIN_TWO  = 2'd3
  } coin_e;

endpackage

// File: rtl/vend_coin_sel.sv
module vend_coin_sel
  import vend_pkg::*;
(
  input  logic  coin_qtr,
  input  logic  coin_one,
  input  logic  coin_two,
  output coin_e sel
);

  // Largest denomination wins; smaller ones in the same cycle are dropped.
  always_comb begin
    if (coin_two)      sel = COIN_TWO;
    else if (coin_one) sel = COIN_ONE;
    else if (coin_qtr) sel = COIN_QTR;
    else               sel = COIN_NONE;
  end

endmodule

// File: rtl/vend_credit_calc.sv
module vend_credit_calc
  import vend_pkg::*;
#(
  parameter int QTR_UNITS   = 1,
  parameter int ONE_UNITS   = 4,
  parameter int TWO_UNITS   = 8,
  parameter int PRICE_UNITS = 4,
  parameter int CHG_W       = 3,
  parameter int CREDIT_W    = 2,
  parameter int SUM_W       = 4
) (
  input  logic [CREDIT_W-1:0] credit,
  input  coin_e               sel,
  output logic                hit,
  output logic [CHG_W-1:0]    surplus,
  output logic [CREDIT_W-1:0] credit_nxt
);

  logic [SUM_W-1:0] coin_val;
  logic [SUM_W-1:0] total;

  always_comb begin
    unique case (sel)
      COIN_QTR: coin_val = SUM_W'(QTR_UNITS);
      COIN_ONE: coin_val = SUM_W'(ONE_UNITS);
      COIN_TWO: coin_val = SUM_W'(TWO_UNITS);
      default:  coin_val = '0;
    endcase
  end

  assign total = SUM_W'(credit) + coin_val;

  always_comb begin
    if (total >= SUM_W'(PRICE_UNITS)) begin
      hit        = 1'b1;
      surplus    = CHG_W'(total - SUM_W'(PRICE_UNITS));
      credit_nxt = '0;
    end else begin
      hit        = 1'b0;
      surplus    = '0;
      credit_nxt = CREDIT_W'(total);
    end
  end

endmodule

// File: rtl/vend_credit_reg.sv
module vend_credit_reg #(
  parameter int CREDIT_W = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CREDIT_W-1:0] credit_nxt,
  output logic [CREDIT_W-1:0] credit_q
);

  always_ff @(posedge clk) begin
    if (rst) credit_q <= '0;
    else     credit_q <= credit_nxt;
  end

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
#(
  parameter int QTR_UNITS   = 1,
  parameter int ONE_UNITS   = 4,
  parameter int TWO_UNITS   = 8,
  parameter int PRICE_UNITS = 4,
  parameter int CHG_W       = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             coin_qtr,
  input  logic             coin_one,
  input  logic             coin_two,
  output logic             dispense,
  output logic [CHG_W-1:0] change
);

  localparam int CREDIT_W = $clog2(PRICE_UNITS);
  localparam int SUM_W    = CHG_W + 1;

  coin_e               sel;
  logic                hit;
  logic [CHG_W-1:0]    surplus;
  logic [CREDIT_W-1:0] credit_nxt;
  logic [CREDIT_W-1:0] credit_q;

  vend_coin_sel u_sel (
    .coin_qtr (coin_qtr),
    .coin_one (coin_one),
    .coin_two (coin_two),
    .sel      (sel)
  );

  vend_credit_calc #(
    .QTR_UNITS   (QTR_UNITS),
    .ONE_UNITS   (ONE_UNITS),
    .TWO_UNITS   (TWO_UNITS),
    .PRICE_UNITS (PRICE_UNITS),
    .CHG_W       (CHG_W),
    .CREDIT_W    (CREDIT_W),
    .SUM_W       (SUM_W)
  ) u_calc (
    .credit     (credit_q),
    .sel        (sel),
    .hit        (hit),
    .surplus    (surplus),
    .credit_nxt (credit_nxt)
  );

  vend_credit_reg #(
    .CREDIT_W (CREDIT_W)
  ) u_reg (
    .clk        (clk),
    .rst        (rst),
    .credit_nxt (credit_nxt),
    .credit_q   (credit_q)
  );

  // Outputs are quiet while reset is held.
  assign dispense = hit & ~rst;
  assign change   = rst ? '0 : surplus;

endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk #(
  parameter int CHG_W       = 3,
  parameter int CREDIT_W    = 2,
  parameter int PRICE_UNITS = 4,
  parameter int TWO_UNITS   = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                coin_qtr,
  input logic                coin_one,
  input logic                coin_two,
  input logic                dispense,
  input logic [CHG_W-1:0]    change,
  input logic [CREDIT_W-1:0] credit_q
);

  logic any_coin;
  assign any_coin = coin_qtr | coin_one | coin_two;

  // R1
  always @(posedge clk) begin
    if (rst) begin
      reset_quiet_chk: assert (!dispense && change == '0)
        else $error("outputs active during reset");
    end
  end

  // R8
  no_change_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !dispense |-> change == '0);

  // R8
  no_coin_no_item_chk: assert property (@(posedge clk) disable iff (rst)
    !any_coin |-> !dispense);

  // R5
  clear_after_item_chk: assert property (@(posedge clk) disable iff (rst)
    dispense |=> credit_q == '0);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !any_coin |=> $stable(credit_q));

  // R2
  qtr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (coin_qtr && !coin_one && !coin_two && credit_q != CREDIT_W'(PRICE_UNITS - 1))
      |=> credit_q == CREDIT_W'($past(credit_q) + 1'b1));

  // R3
  one_item_chk: assert property (@(posedge clk) disable iff (rst)
    (coin_one && !coin_two) |-> (dispense && change == CHG_W'(credit_q)));

  // R4
  two_item_chk: assert property (@(posedge clk) disable iff (rst)
    coin_two |-> (dispense && change == CHG_W'(credit_q) + CHG_W'(TWO_UNITS - PRICE_UNITS)));

endmodule

bind vend_ctrl vend_ctrl_chk #(
  .CHG_W       (CHG_W),
  .CREDIT_W    (CREDIT_W),
  .PRICE_UNITS (PRICE_UNITS),
  .TWO_UNITS   (TWO_UNITS)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .coin_qtr (coin_qtr),
  .coin_one (coin_one),
  .coin_two (coin_two),
  .dispense (dispense),
  .change   (change),
  .credit_q (credit_q)
);

// File: tb/test_vend_ctrl.sv
`timescale 1ns/1ps
module test_vend_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       coin_qtr = 1'b0;
  logic       coin_one = 1'b0;
  logic       coin_two = 1'b0;
  logic       dispense;
  logic [2:0] change;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  vend_ctrl i_vend_ctrl (
    .clk      (clk),
    .rst      (rst),
    .coin_qtr (coin_qtr),
    .coin_one (coin_one),
    .coin_two (coin_two),
    .dispense (dispense),
    .change   (change)
  );

  // Vector: {rst, two, one, qtr, exp_dispense, exp_change[2:0]}, req id in low nibble of tag table
  localparam int NV = 39;
  localparam logic [7:0] VEC [NV] = '{
    8'b1_0_0_1_0_000, // 0  R1 reset masks quarter
    8'b1_1_0_0_0_000, // 1  R1 reset masks two-dollar
    8'b0_0_0_0_0_000, // 2  R8 idle
    8'b0_0_0_1_0_000, // 3  R2 c0->1
    8'b0_0_0_1_0_000, // 4  R2 c1->2
    8'b0_0_0_0_0_000, // 5  R6 hold 2
    8'b0_0_0_1_0_000, // 6  R2 c2->3
    8'b0_0_0_1_1_000, // 7  R2 fourth quarter releases, change 0
    8'b0_0_0_0_0_000, // 8  R8 pulse ends
    8'b0_0_1_0_1_000, // 9  R3 one on c0
    8'b0_0_0_1_0_000, // 10 R2
    8'b0_0_1_0_1_001, // 11 R3 one on c1
    8'b0_0_0_1_0_000, // 12
    8'b0_0_0_1_0_000, // 13
    8'b0_0_1_0_1_010, // 14 R3 one on c2
    8'b0_0_0_1_0_000, // 15
    8'b0_0_0_1_0_000, // 16
    8'b0_0_0_1_0_000, // 17
    8'b0_0_1_0_1_011, // 18 R3 one on c3
    8'b0_1_0_0_1_100, // 19 R4 two on c0
    8'b0_0_0_1_0_000, // 20
    8'b0_0_0_1_0_000, // 21
    8'b0_0_0_1_0_000, // 22
    8'b0_1_0_0_1_111, // 23 R4 two on c3 gives 7
    8'b0_0_0_1_0_000, // 24
    8'b0_1_0_0_1_101, // 25 R4 two on c1
    8'b0_0_0_1_0_000, // 26
    8'b0_0_0_1_0_000, // 27
    8'b0_1_0_0_1_110, // 28 R4 two on c2
    8'b0_0_0_1_0_000, // 29 c1
    8'b0_1_1_1_1_101, // 30 R7 all strobes: two wins
    8'b0_0_1_1_1_000, // 31 R7 one+quarter: quarter dropped
    8'b0_0_0_1_0_000, // 32 R5 credit was zero
    8'b0_0_0_1_0_000, // 33 R5
    8'b0_0_0_1_0_000, // 34 R5
    8'b0_0_0_1_1_000, // 35 R5 fourth quarter after release
    8'b0_0_0_1_0_000, // 36 c1
    8'b1_0_0_0_0_000, // 37 R1 reset clears credit
    8'b0_0_1_0_1_000  // 38 R1 one after reset, change 0
  };
  localparam int VTAG [NV] = '{1,1,8,2,2,6,2,2,8,3,2,3,2,2,3,2,2,2,3,4,2,2,2,4,2,4,2,2,4,2,7,7,5,5,5,5,2,1,1};

  task automatic check(input string req, input logic d, input logic [2:0] c,
                       input logic ed, input logic [2:0] ec);
    checks++;
    if (d !== ed || c !== ec) begin
      errors++;
      $display("FAIL %s: dispense=%0b change=%0d expected dispense=%0b change=%0d",
               req, d, c, ed, ec);
    end
  endtask

  task automatic drive(input logic r, input logic t, input logic o, input logic q);
    rst = r; coin_two = t; coin_one = o; coin_qtr = q;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // Reset state (R1)
    drive(1, 0, 0, 0);
    @(negedge clk); @(negedge clk);
    #5 check("R1", dispense, change, 1'b0, 3'd0);

    // Vector walk: inputs at negedge, outputs sampled 5 ns later (R9: same cycle)
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4]);
      #5 check($sformatf("R%0d/R9 vec%0d", VTAG[i], i), dispense, change,
               VEC[i][3], VEC[i][2:0]);
    end

    // R6: long idle gap keeps credit of 2 quarters
    @(negedge clk); drive(0, 0, 0, 1);
    @(negedge clk); drive(0, 0, 0, 1);
    for (int k = 0; k < 25; k++) begin
      @(negedge clk); drive(0, 0, 0, 0);
      #5 check("R6 idle", dispense, change, 1'b0, 3'd0);
    end
    @(negedge clk); drive(0, 0, 1, 0);
    #5 check("R6 held credit", dispense, change, 1'b1, 3'd2);

    // R8: pulse is a single cycle
    @(negedge clk); drive(0, 0, 0, 0);
    #5 check("R8 single pulse", dispense, change, 1'b0, 3'd0);

    // R7: two+quarter on credit 3 -> 7, quarter dropped, credit zero after
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); drive(0, 0, 0, 1);
    end
    @(negedge clk); drive(0, 1, 0, 1);
    #5 check("R7 two over quarter", dispense, change, 1'b1, 3'd7);
    @(negedge clk); drive(0, 0, 1, 0);
    #5 check("R7/R5 credit cleared", dispense, change, 1'b1, 3'd0);

    // R1: reset mid-credit with a coin present
    @(negedge clk); drive(0, 0, 0, 1);
    @(negedge clk); drive(1, 0, 1, 0);
    #5 check("R1 reset masks one", dispense, change, 1'b0, 3'd0);
    @(negedge clk); drive(0, 1, 0, 0);
    #5 check("R1 credit after reset", dispense, change, 1'b1, 3'd4);

    @(negedge clk); drive(0, 0, 0, 0);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule